// File: doc/BRIEF.md
# Audio Playback Sample FIFO

This block is the transmit half of an on-chip audio output peripheral. Software or a DMA engine writes PCM words into a 64-entry sample queue through a 32-bit register port. A programmable pacer, driven by a sample-rate code, produces one output strobe per audio frame. At each strobe the block removes one (mono) or two (stereo, left then right) entries from the queue and presents them as a pair of 24-bit channel samples, together with a one-cycle valid pulse.

Incoming words are widened to 24 bits when they are written. A 24-bit word is taken from the upper bits of the bus word. A 16-bit word has its eight low bits filled either with zeros or with copies of its sign bit. A DMA request line uses hysteresis: it rises when enough room is free and falls only when room drops below a separate, lower threshold. When a strobe finds too few entries, the block either outputs silence or repeats the previous frame, and it records the event. Writes to a full queue are dropped and also recorded.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the control register reads 0, status reads 64 free entries with both flags clear, and dma_req, sample_valid, left_out and right_out are 0.
- R2: The control register at byte address 0x04 stores its fields and reads them back: rate code [31:29], filter select [28], underrun policy [26], expansion mode [24], request-clear code [22:21], trigger level [13:8], mono [6], width [5] and request enable [4]. Bit 0 always reads 0. filter_sel follows bit 28.
- R3: The pacer strobe period in clock cycles is 512, 768, 1024, 1536, 2048, 3072, 128 and 256 for rate codes 0 to 7.
- R4: The queue holds 64 entries in first-in first-out order. The status register at 0x08 reports the free-entry count in bits [6:0].
- R5: In stereo mode (bit 6 = 0), each strobe takes two consecutive entries, the older one to left_out and the newer one to right_out.
- R6: In mono mode (bit 6 = 1), each strobe takes one entry and drives it to both channels.
- R7: A word written to the data register at 0x0C is stored as follows. With bit 5 = 1 it is stored as wdata[31:8]. With bit 5 = 0 it is stored as {wdata[15:0], fill}, where fill is eight copies of wdata[15] when bit 24 = 1 and zeros when bit 24 = 0.
- R8: A strobe that finds fewer entries than one frame needs removes nothing. It sets the sticky status bit 31, which is cleared by writing 1 to it. With bit 26 = 0 both outputs become 0; with bit 26 = 1 they keep their previous values.
- R9: A write to the data register while the queue is full is discarded and sets status bit 30, which is cleared by writing 1 to it.
- R10: Writing the control register with bit 0 = 1 empties the queue by the next clock.
- R11: With bit 4 = 1, dma_req rises when the free count is at or above the trigger level. It falls when the free count is below 2 << clear code, and holds otherwise. With bit 4 = 0 it is 0. The request follows a change in the count by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| dma_req | output | 1 | DMA service request |
| sample_valid | output | 1 | One-cycle pulse marking a new output frame |
| left_out | output | 24 | Left channel sample |
| right_out | output | 24 | Right channel sample |
| filter_sel | output | 1 | Stored filter-variant select |

## Verification
Register reads are combinational, so status and control are checked in the same cycle as the read. A register or data write takes effect at the next clock edge. dma_req trails a queue change by one further edge, so the bench waits an extra cycle before it samples the request. Channel outputs change at the edge that raises sample_valid. Each data scenario first waits for a strobe and then writes its whole frame well inside one pacer period, so no strobe can split a frame. Periods are measured as the number of cycles between two valid pulses, taken only after two strobes at the new rate.

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int DEPTH    = 64,
  parameter int BASE_DIV = 512
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        dma_req,
  output logic        sample_valid,
  output logic [23:0] left_out,
  output logic [23:0] right_out,
  output logic        filter_sel
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = AW + 1;
  localparam int CW = $clog2(BASE_DIV * 6);
  localparam logic [7:0]  A_CTRL    = 8'h04;
  localparam logic [7:0]  A_STAT    = 8'h08;
  localparam logic [7:0]  A_DATA    = 8'h0C;
  localparam logic [31:0] CTRL_MASK = 32'hF560_3F70;

  logic [31:0]   ctrl;
  logic [23:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [FW-1:0] count;
  logic [CW-1:0] pcnt, period;
  logic          uflow, oflow;
  logic [23:0]   in_s;

  wire [2:0] rate      = ctrl[31:29];
  wire       hold_last = ctrl[26];
  wire       expand    = ctrl[24];
  wire [1:0] clr       = ctrl[22:21];
  wire [5:0] trig      = ctrl[13:8];
  wire       mono      = ctrl[6];
  wire       wide      = ctrl[5];
  wire       drq_en    = ctrl[4];
  assign filter_sel = ctrl[28];

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire flush   = wr_ctrl && bus_wdata[0];
  wire full    = count == FW'(DEPTH);
  wire push    = wr_data && !full;

  wire [FW-1:0] free  = FW'(DEPTH) - count;
  wire [FW-1:0] thr   = FW'(2) << clr;
  wire [FW-1:0] need  = mono ? FW'(1) : FW'(2);
  wire          tick  = pcnt >= period - CW'(1);
  wire          have  = count >= need;
  wire [FW-1:0] pop_n = (tick && have) ? need : '0;
  wire [AW-1:0] rd_nx = rd_ptr + AW'(1);

  always_comb begin
    case (rate)
      3'd0:    period = CW'(BASE_DIV);
      3'd1:    period = CW'(BASE_DIV * 3 / 2);
      3'd2:    period = CW'(BASE_DIV * 2);
      3'd3:    period = CW'(BASE_DIV * 3);
      3'd4:    period = CW'(BASE_DIV * 4);
      3'd5:    period = CW'(BASE_DIV * 6);
      3'd6:    period = CW'(BASE_DIV / 4);
      default: period = CW'(BASE_DIV / 2);
    endcase
  end

  always_comb
    in_s = wide ? bus_wdata[31:8]
                : {bus_wdata[15:0], expand ? {8{bus_wdata[15]}} : 8'h00};

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= in_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; rd_ptr <= '0; wr_ptr <= '0; count <= '0; pcnt <= '0;
      uflow <= 1'b0; oflow <= 1'b0; dma_req <= 1'b0;
      sample_valid <= 1'b0; left_out <= '0; right_out <= '0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata & CTRL_MASK;
      if (flush) begin
        rd_ptr <= '0; wr_ptr <= '0; count <= '0;
      end else begin
        wr_ptr <= wr_ptr + AW'(push);
        rd_ptr <= rd_ptr + AW'(pop_n);
        count  <= count + FW'(push) - pop_n;
      end
      pcnt <= tick ? '0 : pcnt + CW'(1);
      sample_valid <= tick;
      if (tick) begin
        if (have) begin
          left_out  <= mem[rd_ptr];
          right_out <= mono ? mem[rd_ptr] : mem[rd_nx];
        end else if (!hold_last) begin
          left_out  <= '0;
          right_out <= '0;
        end
      end
      if (tick && !have)                   uflow <= 1'b1;
      else if (wr_stat && bus_wdata[31])   uflow <= 1'b0;
      if (wr_data && full)                 oflow <= 1'b1;
      else if (wr_stat && bus_wdata[30])   oflow <= 1'b0;
      if (!drq_en)                 dma_req <= 1'b0;
      else if (free >= FW'(trig))  dma_req <= 1'b1;
      else if (free < thr)         dma_req <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = {uflow, oflow, {(30-FW){1'b0}}, free};
      default: bus_rdata = '0;
    endcase
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FW'(DEPTH));
  a_r11_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !drq_en |=> !dma_req);
  a_r11_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    drq_en && free < thr && free < FW'(trig) && !flush && !push |=> !dma_req);
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> bus_addr != A_STAT || bus_rdata[FW-1:0] == FW'(DEPTH) || bus_wr);
  a_r10_flush_count: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> free == FW'(DEPTH));
  a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && full |=> oflow);
  a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !have && !hold_last |=> left_out == '0 && right_out == '0);
  a_r8_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !have && hold_last |=> $stable(left_out) && $stable(right_out));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !have |=> uflow);
  a_r6_mono_pair: assert property (@(posedge clk) disable iff (!rst_n)
    tick && have && mono |=> left_out == right_out);
endmodule

// File: tb/audio_tx_fifo_test.sv
module audio_tx_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        dma_req, sample_valid, filter_sel;
  logic [23:0] left_out, right_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [7:0] CTRL = 8'h04, STAT = 8'h08, DATA = 8'h0C;

  always #5 clk = ~clk;

  audio_tx_fifo uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req),
    .sample_valid(sample_valid), .left_out(left_out), .right_out(right_out),
    .filter_sel(filter_sel));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int rate, int filt, int hold, int expd, int clr,
                                     int trig, int mono, int wide, int drq, int fl);
    return (32'(rate) << 29) | (32'(filt) << 28) | (32'(hold) << 26) | (32'(expd) << 24) |
           (32'(clr) << 21) | (32'(trig) << 8) | (32'(mono) << 6) | (32'(wide) << 5) |
           (32'(drq) << 4) | 32'(fl);
  endfunction

  function automatic int exp_period(int c);
    case (c)
      0: return 512;  1: return 768;  2: return 1024; 3: return 1536;
      4: return 2048; 5: return 3072; 6: return 128;  default: return 256;
    endcase
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_strobe();
    @(negedge clk);
    while (!sample_valid) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(CTRL, v); check("R1", "ctrl after reset", v, 32'h0);
    rd(STAT, v); check("R1", "status after reset", v, 32'd64);
    check("R1", "dma_req", {31'b0, dma_req}, 0);
    check("R1", "sample_valid", {31'b0, sample_valid}, 0);
    check("R1", "outputs", {8'b0, left_out | right_out}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v, w;
    w = mk(5, 1, 1, 1, 2, 37, 1, 1, 0, 1);
    wr(CTRL, w);
    rd(CTRL, v); check("R2", "ctrl readback", v, w & 32'hFFFF_FFFE);
    check("R2", "filter_sel high", {31'b0, filter_sel}, 1);
    wr(CTRL, mk(5, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    check("R2", "filter_sel low", {31'b0, filter_sel}, 0);
  endtask

  task automatic t_stereo16();
    wr(CTRL, mk(6, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wait_strobe();
    wr(DATA, 32'hAAAA_1234); wr(DATA, 32'h5555_FEDC);
    wait_strobe();
    check("R5", "stereo left", {8'b0, left_out}, 32'h12_3400);
    check("R7", "stereo right zero fill", {8'b0, right_out}, 32'hFE_DC00);
  endtask

  task automatic t_expand();
    wr(CTRL, mk(6, 0, 0, 1, 0, 0, 0, 0, 0, 1));
    wait_strobe();
    wr(DATA, 32'h0000_8001); wr(DATA, 32'h0000_1234);
    wait_strobe();
    check("R7", "sign fill negative", {8'b0, left_out}, 32'h80_01FF);
    check("R7", "sign fill positive", {8'b0, right_out}, 32'h12_3400);
  endtask

  task automatic t_wide();
    wr(CTRL, mk(6, 0, 0, 1, 0, 0, 0, 1, 0, 1));
    wait_strobe();
    wr(DATA, 32'hABCD_EF12); wr(DATA, 32'h0123_4567);
    wait_strobe();
    check("R7", "24-bit left", {8'b0, left_out}, 32'hAB_CDEF);
    check("R7", "24-bit right", {8'b0, right_out}, 32'h01_2345);
  endtask

  task automatic t_mono();
    wr(CTRL, mk(6, 0, 0, 0, 0, 0, 1, 0, 0, 1));
    wait_strobe();
    wr(DATA, 32'h0000_5555); wr(DATA, 32'h0000_6666);
    wait_strobe();
    check("R6", "mono left", {8'b0, left_out}, 32'h55_5500);
    check("R6", "mono right", {8'b0, right_out}, 32'h55_5500);
    wait_strobe();
    check("R6", "mono second entry", {8'b0, right_out}, 32'h66_6600);
  endtask

  task automatic t_under_zero();
    logic [31:0] v;
    wr(CTRL, mk(6, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wait_strobe();
    wr(DATA, 32'h0000_7777);
    wait_strobe();
    check("R8", "zero policy left", {8'b0, left_out}, 0);
    check("R8", "zero policy right", {8'b0, right_out}, 0);
    rd(STAT, v); check("R8", "underrun flag set", {31'b0, v[31]}, 1);
    check("R8", "partial frame kept", {25'b0, v[6:0]}, 63);
    wr(STAT, 32'h8000_0000);
    rd(STAT, v); check("R8", "underrun flag cleared", {31'b0, v[31]}, 0);
  endtask

  task automatic t_under_hold();
    logic [31:0] v;
    wr(CTRL, mk(6, 0, 1, 0, 0, 0, 0, 0, 0, 1));
    wait_strobe();
    wr(STAT, 32'h8000_0000);
    wr(DATA, 32'h0000_1111); wr(DATA, 32'h0000_2222);
    wait_strobe();
    check("R5", "hold test left", {8'b0, left_out}, 32'h11_1100);
    wait_strobe();
    check("R8", "repeat left", {8'b0, left_out}, 32'h11_1100);
    check("R8", "repeat right", {8'b0, right_out}, 32'h22_2200);
    rd(STAT, v); check("R8", "underrun on repeat", {31'b0, v[31]}, 1);
  endtask

  task automatic t_overrun_order();
    logic [31:0] v;
    wr(CTRL, mk(5, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wait_strobe();
    wr(STAT, 32'hC000_0000);
    for (int i = 0; i < 3; i++) wr(DATA, 32'h0100 + 32'(i));
    rd(STAT, v); check("R4", "free after three", v, 32'd61);
    for (int i = 3; i < 64; i++) wr(DATA, 32'h0100 + 32'(i));
    rd(STAT, v); check("R4", "free when full", {25'b0, v[6:0]}, 0);
    check("R9", "no overrun yet", {31'b0, v[30]}, 0);
    wr(DATA, 32'h0000_BEEF);
    rd(STAT, v); check("R9", "overrun flag", {31'b0, v[30]}, 1);
    check("R9", "still full", {25'b0, v[6:0]}, 0);
    wr(STAT, 32'h4000_0000);
    rd(STAT, v); check("R9", "overrun cleared", {31'b0, v[30]}, 0);
    wr(CTRL, mk(6, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    for (int i = 0; i < 64; i++) begin
      wait_strobe();
      if (i == 0 || i == 63)
        check("R4", "fifo order", {8'b0, left_out}, {8'b0, 16'h0100 + 16'(i), 8'h00});
    end
    wait_strobe();
    check("R9", "dropped word absent", {8'b0, left_out}, 0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    wr(CTRL, mk(5, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wait_strobe();
    for (int i = 0; i < 5; i++) wr(DATA, 32'(i));
    rd(STAT, v); check("R10", "filled", {25'b0, v[6:0]}, 59);
    wr(CTRL, mk(5, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    rd(STAT, v); check("R10", "flushed", {25'b0, v[6:0]}, 64);
  endtask

  task automatic t_dma();
    wr(CTRL, mk(5, 0, 0, 0, 3, 40, 0, 0, 1, 1));
    wait_strobe();
    @(negedge clk);
    check("R11", "request with empty fifo", {31'b0, dma_req}, 1);
    for (int i = 0; i < 44; i++) wr(DATA, 32'(i));
    @(negedge clk);
    check("R11", "hysteresis hold at 20 free", {31'b0, dma_req}, 1);
    for (int i = 0; i < 5; i++) wr(DATA, 32'(i));
    @(negedge clk);
    check("R11", "dropped below 16 free", {31'b0, dma_req}, 0);
    wr(CTRL, mk(5, 0, 0, 0, 3, 40, 0, 0, 1, 1));
    @(negedge clk);
    check("R11", "request after flush", {31'b0, dma_req}, 1);
    wr(CTRL, mk(5, 0, 0, 0, 3, 40, 0, 0, 0, 0));
    @(negedge clk);
    check("R11", "request disabled", {31'b0, dma_req}, 0);
  endtask

  task automatic t_pace();
    for (int c = 0; c < 8; c++) begin
      int n;
      wr(CTRL, mk(c, 0, 0, 0, 0, 0, 0, 0, 0, 1));
      wait_strobe(); wait_strobe();
      n = 0;
      do begin @(negedge clk); n++; end while (!sample_valid);
      check("R3", $sformatf("period code %0d", c), 32'(n), 32'(exp_period(c)));
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_stereo16();
    t_expand();
    t_wide();
    t_mono();
    t_under_zero();
    t_under_hold();
    t_overrun_order();
    t_flush();
    t_dma();
    t_pace();
    done = 1;
    report();
  end
endmodule